// File: doc/BRIEF.md
# SONET A1/A2 Frame Alignment Tracker

This block follows frame alignment on a byte-wide STS-12 receive stream that has already been byte-aligned. While it has no alignment it hunts for the A1/A2 framing boundary at every byte position. Once it finds the boundary, it re-checks the boundary once per frame, at the byte where the next one is due. A short confirmation run must pass before the frame is declared good. After that, a single missed boundary is tolerated for one frame before alignment is dropped.

Downstream logic uses four outputs. The in-frame flag qualifies the payload as valid. The out-of-frame alarm reports loss of alignment. A frame-sync pulse marks each expected boundary byte. The current alignment state is also exposed. A saturating counter tallies errored frames, and a host can read it and clear it.

Top module: `sfa_frame_align`

## Requirements
- R1: After reset the block reports state code 0 (out-of-frame), the alarm is high, in-frame is low, frame-sync is low and the errored-frame count is zero.
- R2: In out-of-frame, a match on the last CMP_A1 bytes of 0xF6 followed by the first CMP_A2 bytes of 0x28 (defaults 2 and 2) at any position moves the state to code 1 (confirm) on the next cycle. The byte that completes the match becomes frame position 0.
- R3: Frame-sync is high during the byte at frame position 0, which recurs every FRAME_LEN bytes, whenever the state is not out-of-frame. It is never high in out-of-frame.
- R4: In-frame (code 2) is declared at the check where CONFIRM_NEEDED consecutive correct comparisons have been seen, counting the finding match as the first. A failed check while in confirm returns the state to out-of-frame.
- R5: In in-frame, a correct check keeps the state. A failed check moves it to errored-frame (code 3) and increments the errored-frame count by one.
- R6: In errored-frame, a correct check returns the state to in-frame. A second consecutive failed check moves it to out-of-frame, which raises the alarm.
- R7: A valid pattern that completes away from frame position 0 while in confirm, in-frame or errored-frame changes nothing: not the state, not frame-sync, and not the frame position.
- R8: in_frame_o is high exactly in state code 2, and oof_alarm_o is high exactly in state code 0.
- R9: The errored-frame count holds at its all-ones value instead of wrapping.
- R10: A high err_clr_i sets the count to zero on the next cycle and has no effect on the alignment state.
- R11: Outside out-of-frame, the state changes only at a cycle where frame-sync is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_byte_i | input | 8 | Received byte, one per clock |
| err_clr_i | input | 1 | Host pulse that clears the errored-frame count |
| in_frame_o | output | 1 | Alignment is good and payload is valid |
| oof_alarm_o | output | 1 | Out-of-frame alarm |
| frame_sync_o | output | 1 | Marks the expected boundary byte (frame position 0) |
| align_state_o | output | 2 | 0 out-of-frame, 1 confirm, 2 in-frame, 3 errored-frame |
| err_count_o | output | ERR_W | Saturating errored-frame count |

## Verification
The bench drives whole frames of good and spoiled framing through every state transition. A block that counted the finding match wrongly would declare in-frame one frame early or one frame late. A block that skipped the grace state would drop to out-of-frame after a single miss. A framing pattern is also placed mid-frame while in confirm and in in-frame. A design that re-synchronised on it would move its sync pulse away from the true boundary and then fail the next real check. The count is driven past its small bench width to expose wrap-around. A clear pulse must zero the count without disturbing alignment. An asynchronous reset in mid-run must return every output to its idle value at once.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  typedef enum logic [1:0] {
    ST_OOF     = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_INFRAME = 2'd2,
    ST_ERRORED = 2'd3
  } align_st_e;

  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;

endpackage

// File: rtl/sfa_rst_sync.sv
module sfa_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sfa_pattern_det.sv
module sfa_pattern_det
  import sfa_pkg::*;
#(
  parameter int CMP_A1 = 2,
  parameter int CMP_A2 = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  output logic       hit_o
);
  localparam int WIN = CMP_A1 + CMP_A2;

  // win[0] is the byte on the input now, win[WIN-1] the oldest one held
  logic [7:0]     win    [WIN];
  logic [7:0]     hist_q [1:WIN-1];
  logic [WIN-1:0] byte_ok;

  assign win[0] = byte_i;

  for (genvar g = 1; g < WIN; g++) begin : g_hist
    if (g == 1) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q[g] <= 8'h00;
        else         hist_q[g] <= byte_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q[g] <= 8'h00;
        else         hist_q[g] <= hist_q[g-1];
      end
    end
    assign win[g] = hist_q[g];
  end

  for (genvar g = 0; g < WIN; g++) begin : g_cmp
    if (g < CMP_A2) begin : g_a2
      assign byte_ok[g] = (win[g] == A2_BYTE);
    end else begin : g_a1
      assign byte_ok[g] = (win[g] == A1_BYTE);
    end
  end

  assign hit_o = &byte_ok;
endmodule

// File: rtl/sfa_frame_ctr.sv
module sfa_frame_ctr #(
  parameter int FRAME_LEN = 9720
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic at_check_o
);
  localparam int              CW   = $clog2(FRAME_LEN);
  localparam logic [CW-1:0]   LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] pos_q, pos_d;

  always_comb begin
    if (restart_i)          pos_d = CW'(1);
    else if (pos_q == LAST) pos_d = '0;
    else                    pos_d = pos_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign at_check_o = (pos_q == '0);
endmodule

// File: rtl/sfa_err_cnt.sv
module sfa_err_cnt #(
  parameter int ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [ERR_W-1:0] count_o
);
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | (inc_i & (cnt_q != '1));

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + ERR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sfa_frame_align.sv
module sfa_frame_align
  import sfa_pkg::*;
#(
  parameter int FRAME_LEN      = 9720,
  parameter int CMP_A1         = 2,
  parameter int CMP_A2         = 2,
  parameter int CONFIRM_NEEDED = 4,
  parameter int ERR_W          = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       rx_byte_i,
  input  logic             err_clr_i,
  output logic             in_frame_o,
  output logic             oof_alarm_o,
  output logic             frame_sync_o,
  output logic [1:0]       align_state_o,
  output logic [ERR_W-1:0] err_count_o
);
  localparam int            GW       = $clog2(CONFIRM_NEEDED + 1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(CONFIRM_NEEDED - 1);

  logic      rst_n_q;
  logic      hit;
  logic      at_check;
  logic      restart;
  logic      err_inc;
  align_st_e state_q, state_d;
  logic [GW-1:0] good_q, good_d;

  sfa_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  sfa_pattern_det #(
    .CMP_A1 (CMP_A1),
    .CMP_A2 (CMP_A2)
  ) u_pattern_det (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .byte_i (rx_byte_i),
    .hit_o  (hit)
  );

  sfa_frame_ctr #(
    .FRAME_LEN (FRAME_LEN)
  ) u_frame_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_q),
    .restart_i  (restart),
    .at_check_o (at_check)
  );

  sfa_err_cnt #(
    .ERR_W (ERR_W)
  ) u_err_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .clr_i   (err_clr_i),
    .inc_i   (err_inc),
    .count_o (err_count_o)
  );

  always_comb begin
    state_d = state_q;
    good_d  = good_q;
    restart = 1'b0;
    err_inc = 1'b0;
    unique case (state_q)
      ST_OOF: begin
        if (hit) begin
          state_d = ST_CONFIRM;
          good_d  = GW'(1);
          restart = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (at_check) begin
          if (!hit) begin
            state_d = ST_OOF;
          end else if (good_q == GOOD_TOP) begin
            state_d = ST_INFRAME;
          end else begin
            good_d = good_q + GW'(1);
          end
        end
      end
      ST_INFRAME: begin
        if (at_check && !hit) begin
          state_d = ST_ERRORED;
          err_inc = 1'b1;
        end
      end
      ST_ERRORED: begin
        if (at_check) state_d = hit ? ST_INFRAME : ST_OOF;
      end
      default: state_d = ST_OOF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      state_q <= ST_OOF;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
    end
  end

  assign in_frame_o    = (state_q == ST_INFRAME);
  assign oof_alarm_o   = (state_q == ST_OOF);
  assign frame_sync_o  = at_check & (state_q != ST_OOF);
  assign align_state_o = state_q;
endmodule

// File: rtl/sfa_frame_align_chk.sv
module sfa_frame_align_chk
  import sfa_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             err_clr_i,
  input logic             in_frame_o,
  input logic             frame_sync_o,
  input logic [1:0]       align_state_o,
  input logic [ERR_W-1:0] err_count_o
);
  // R2
  oof_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (align_state_o == ST_OOF) |=> (align_state_o == ST_OOF || align_state_o == ST_CONFIRM));

  // R11
  state_at_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (align_state_o != ST_OOF && !frame_sync_o) |=> $stable(align_state_o));

  // R5
  count_only_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!err_clr_i && align_state_o != ST_INFRAME) |=> $stable(err_count_o));

  // R10
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_clr_i |=> (err_count_o == '0));

  // R4
  in_frame_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(in_frame_o) |-> ($past(align_state_o) == ST_CONFIRM || $past(align_state_o) == ST_ERRORED));

  // R6
  errored_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (align_state_o == ST_ERRORED) |=> (align_state_o != ST_CONFIRM));

  // R9
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (err_count_o == '1 && !err_clr_i) |=> (err_count_o == '1));
endmodule

bind sfa_frame_align sfa_frame_align_chk #(
  .ERR_W (ERR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n_q),
  .err_clr_i     (err_clr_i),
  .in_frame_o    (in_frame_o),
  .frame_sync_o  (frame_sync_o),
  .align_state_o (align_state_o),
  .err_count_o   (err_count_o)
);

// File: tb/sfa_frame_align_bench.sv
module sfa_frame_align_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN        = 40;
  localparam int EW         = 3;
  localparam int NV         = 15;

  // entry: [6] good framing, [5:4] expected state, [3:0] expected count
  localparam logic [6:0] VEC [NV] = '{
    7'b1_01_0000, 7'b1_01_0000, 7'b1_01_0000, 7'b1_10_0000,
    7'b1_10_0000, 7'b0_11_0001, 7'b1_10_0001, 7'b0_11_0010,
    7'b0_00_0010, 7'b1_01_0010, 7'b0_00_0010, 7'b1_01_0010,
    7'b1_01_0010, 7'b1_01_0010, 7'b1_10_0010
  };

  logic          clk;
  logic          rst_n;
  logic [7:0]    rx_byte;
  logic          err_clr;
  logic          in_frame, oof_alarm, frame_sync;
  logic [1:0]    state;
  logic [EW-1:0] err_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sfa_frame_align #(
    .FRAME_LEN (LEN),
    .ERR_W     (EW)
  ) u_sfa_frame_align (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rx_byte_i     (rx_byte),
    .err_clr_i     (err_clr),
    .in_frame_o    (in_frame),
    .oof_alarm_o   (oof_alarm),
    .frame_sync_o  (frame_sync),
    .align_state_o (state),
    .err_count_o   (err_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // frame layout: 0..2 0xF6, 3..5 0x28 (match completes at 4), payload after
  task automatic send_frame(input bit good, input bit extra, input bit clr,
                            output bit sync_hit, output bit sync_extra);
    sync_hit   = 0;
    sync_extra = 0;
    for (int p = 0; p < LEN; p++) begin
      logic [7:0] b;
      if (p < 3)                        b = 8'hF6;
      else if (p < 6)                   b = good ? 8'h28 : 8'h00;
      else if (extra && p >= 20 && p < 22) b = 8'hF6;
      else if (extra && p >= 22 && p < 24) b = 8'h28;
      else                              b = 8'(8'h40 + p);
      @(negedge clk);
      rx_byte = b;
      err_clr = clr && (p == 10);
      #1;
      if (p == 4)  sync_hit   = frame_sync;
      if (p == 23) sync_extra = frame_sync;
    end
  endtask

  task automatic check_state(input string req, input int exp_state, input int exp_err);
    check(req, state, exp_state, "state");
    check(req, err_count, exp_err, "error count");
    check("R8", in_frame, exp_state == 2, "in-frame flag");
    check("R8", oof_alarm, exp_state == 0, "alarm");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit sh, sx;
    int prev;
    rst_n   = 1'b0;
    rx_byte = 8'h00;
    err_clr = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset values
    check("R1", state, 0, "state");
    check("R1", oof_alarm, 1, "alarm");
    check("R1", in_frame, 0, "in-frame");
    check("R1", frame_sync, 0, "sync");
    check("R1", err_count, 0, "count");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: R2 R4 R5 R6 and R3 sync at each boundary
    prev = 0;
    for (int i = 0; i < NV; i++) begin
      send_frame(VEC[i][6], 1'b0, 1'b0, sh, sx);
      check("R3", sh, prev != 0, $sformatf("sync at boundary, frame %0d", i));
      check_state(i < 5 ? "R4" : (i < 9 ? "R6" : "R2"), VEC[i][5:4], VEC[i][3:0]);
      prev = VEC[i][5:4];
    end

    // R7 pattern off position while in frame
    send_frame(1'b1, 1'b1, 1'b0, sh, sx);
    check("R7", sx, 0, "sync at misplaced pattern, in-frame");
    check_state("R7", 2, 2);
    send_frame(1'b1, 1'b0, 1'b0, sh, sx);
    check("R7", sh, 1, "boundary kept after misplaced pattern");
    check_state("R5", 2, 2);

    // R10 clear mid-frame, state untouched
    send_frame(1'b1, 1'b0, 1'b1, sh, sx);
    check_state("R10", 2, 0);

    // R9 saturation of the count
    for (int k = 0; k < 9; k++) begin
      send_frame(1'b0, 1'b0, 1'b0, sh, sx);
      check_state("R5", 3, (k + 1 > 7) ? 7 : k + 1);
      send_frame(1'b1, 1'b0, 1'b0, sh, sx);
      check_state("R6", 2, (k + 1 > 7) ? 7 : k + 1);
    end
    check("R9", err_count, 7, "saturated count");

    // R7 pattern off position while confirming
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", state, 0, "state after async reset");
    check("R1", err_count, 0, "count after async reset");
    check("R1", oof_alarm, 1, "alarm after async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_frame(1'b1, 1'b0, 1'b0, sh, sx);
    check_state("R2", 1, 0);
    send_frame(1'b1, 1'b1, 1'b0, sh, sx);
    check("R7", sx, 0, "sync at misplaced pattern, confirm");
    check("R3", sh, 1, "sync in confirm");
    check_state("R7", 1, 0);
    send_frame(1'b1, 1'b0, 1'b0, sh, sx);
    check_state("R4", 1, 0);
    send_frame(1'b1, 1'b0, 1'b0, sh, sx);
    check_state("R4", 2, 0);

    done = 1;
    summary();
  end
endmodule